// File: doc/BRIEF.md
# Quarter-Width Widening Multiply-Subtract Row Unit

This block updates one accumulator row of a fixed vector length in a single registered step. The caller supplies two source vectors, the current accumulator row, a size bit and a 2-bit sub-index. For each wide accumulator element, the block picks one unsigned narrow element from each source vector and multiplies the two. It then subtracts that product from the accumulator element and returns the new row. A narrow element is one quarter of the accumulator element width.

The narrow elements are not taken from the lane that matches the accumulator element. For accumulator element `e`, both sources supply narrow element number `4*e + sub` of the vector. That element lies inside the bit range of accumulator element `e`, at quarter position `sub`. To sweep all four quarters, a sequencer outside the block issues four operations, one per sub-index, each against its own accumulator row. Register storage, decode and row addressing belong to the surrounding logic.

The input side and the output side each use a valid/ready handshake. One output register sits between them. An accepted operation always produces its result exactly one cycle later, whatever the data values are.

Top module: `qwms_lanes`

## Requirements
- R1: With `size_i` = 0, the row is split into VLEN/32 accumulator elements of 32 bits each. Element e occupies bits [32e+31:32e]. The narrow source elements are 8 bits wide, and narrow element k occupies bits [8k+7:8k].
- R2: With `size_i` = 1, the row is split into VLEN/64 accumulator elements of 64 bits each. The narrow source elements are 16 bits wide, and narrow element k occupies bits [16k+15:16k].
- R3: For accumulator element e, both sources supply narrow element k = 4*e + `sub_idx_i`. Both narrow values are treated as unsigned.
- R4: Each result element equals the old accumulator element minus the product of the two narrow elements. The subtraction wraps modulo 2^esize.
- R5: Every accumulator element of the row is updated on every operation. There is no per-element mask.
- R6: An operation is accepted on a rising clock edge where `in_valid_i` and `in_ready_o` are both high. After that edge, `out_valid_o` is high and `res_o` holds that operation's result.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `in_ready_o` is low, and `out_valid_o` and `res_o` keep their values.
- R8: An input presented while `in_ready_o` is low is ignored. It does not change `res_o`, and it is not delivered later unless it is presented again while `in_ready_o` is high.
- R9: When the result is consumed and no new operation is accepted on the same edge, `out_valid_o` drops to 0 after that edge. While the output register is empty, `in_ready_o` is 1.
- R10: After reset, `out_valid_o` is 0 and `in_ready_o` is 1. The one-cycle latency does not depend on the operand values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Operation can be taken this cycle |
| size_i | input | 1 | 0: 32-bit accumulators, 1: 64-bit accumulators |
| sub_idx_i | input | 2 | Quarter position of the narrow elements inside each accumulator element |
| src_a_i | input | VLEN | First source vector |
| src_b_i | input | VLEN | Second source vector |
| acc_i | input | VLEN | Accumulator row before the update |
| out_valid_o | output | 1 | Result row held |
| out_ready_i | input | 1 | Consumer takes the result |
| res_o | output | VLEN | Updated accumulator row |

## Verification
The hardest case to reach is a new input offered while a result is stalled in the output register. Here the ready signal must refuse the new row, and the stored row must survive several cycles untouched. The stimulus reaches this case with a directed sequence. It holds `out_ready_i` low, issues a first row, offers a second, different row for several cycles, and then releases the consumer so that the second row goes through on the drain edge. Random rows cover both sizes and all four sub-indices. Directed all-ones sources over a zero accumulator force the wrap in every lane.

// File: rtl/qwms_pkg.sv
package qwms_pkg;
  typedef enum logic {
    ESZ_32 = 1'b0,
    ESZ_64 = 1'b1
  } esize_e;
endpackage

// File: rtl/qwms_mslane.sv
// One accumulator element: pick quarter sub_idx_i of each source, multiply, subtract.
module qwms_mslane #(
  parameter int EW = 32
) (
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  input  logic [EW-1:0] acc_i,
  input  logic [1:0]    sub_idx_i,
  output logic [EW-1:0] res_o
);
  localparam int NW = EW / 4;

  logic [NW-1:0]   a_sel, b_sel;
  logic [2*NW-1:0] prod;

  always_comb begin
    a_sel = a_i[sub_idx_i*NW +: NW];
    b_sel = b_i[sub_idx_i*NW +: NW];
    prod  = a_sel * b_sel;
    res_o = acc_i - EW'(prod);
  end
endmodule

// File: rtl/qwms_row.sv
module qwms_row #(
  parameter int VLEN = 128,
  parameter int EW   = 32
) (
  input  logic [VLEN-1:0] a_i,
  input  logic [VLEN-1:0] b_i,
  input  logic [VLEN-1:0] acc_i,
  input  logic [1:0]      sub_idx_i,
  output logic [VLEN-1:0] res_o
);
  localparam int NELEM = VLEN / EW;

  for (genvar e = 0; e < NELEM; e++) begin : g_lane
    qwms_mslane #(.EW(EW)) u_lane (
      .a_i      (a_i[e*EW +: EW]),
      .b_i      (b_i[e*EW +: EW]),
      .acc_i    (acc_i[e*EW +: EW]),
      .sub_idx_i(sub_idx_i),
      .res_o    (res_o[e*EW +: EW])
    );
  end
endmodule

// File: rtl/qwms_outreg.sv
module qwms_outreg #(
  parameter int W = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] d_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] q_o
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready_o  = !vld_q || out_ready_i;
  assign out_valid_o = vld_q;
  assign q_o         = dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready_o) begin
      vld_q <= in_valid_i;
      if (in_valid_i) dat_q <= d_i;
    end
  end
endmodule

// File: rtl/qwms_lanes.sv
module qwms_lanes
  import qwms_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic            size_i,
  input  logic [1:0]      sub_idx_i,
  input  logic [VLEN-1:0] src_a_i,
  input  logic [VLEN-1:0] src_b_i,
  input  logic [VLEN-1:0] acc_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [VLEN-1:0] res_o
);
  logic [VLEN-1:0] res32, res64, res_nxt;
  esize_e          esz;

  assign esz = esize_e'(size_i);

  qwms_row #(.VLEN(VLEN), .EW(32)) u_row32 (
    .a_i(src_a_i), .b_i(src_b_i), .acc_i(acc_i),
    .sub_idx_i(sub_idx_i), .res_o(res32)
  );

  qwms_row #(.VLEN(VLEN), .EW(64)) u_row64 (
    .a_i(src_a_i), .b_i(src_b_i), .acc_i(acc_i),
    .sub_idx_i(sub_idx_i), .res_o(res64)
  );

  always_comb begin
    unique case (esz)
      ESZ_64:  res_nxt = res64;
      default: res_nxt = res32;
    endcase
  end

  qwms_outreg #(.W(VLEN)) u_oreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .d_i        (res_nxt),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .q_o        (res_o)
  );
endmodule

// File: rtl/qwms_lanes_chk.sv
module qwms_lanes_chk #(
  parameter int VLEN = 128
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            in_ready_o,
  input logic [VLEN-1:0] src_a_i,
  input logic [VLEN-1:0] acc_i,
  input logic            out_valid_o,
  input logic            out_ready_i,
  input logic [VLEN-1:0] res_o
);
  // R6
  accept_to_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(res_o)));

  // R7
  stall_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  // R9
  drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_ready_i && !in_valid_i) |=> !out_valid_o);

  // R4
  zero_prod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && src_a_i == '0) |=> (res_o == $past(acc_i)));

  // R10
  empty_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);
endmodule

bind qwms_lanes qwms_lanes_chk #(.VLEN(VLEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .src_a_i(src_a_i), .acc_i(acc_i), .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i), .res_o(res_o)
);

// File: tb/qwms_lanes_tb.sv
module qwms_lanes_tb;
  localparam int VLEN = 128;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic            size = 1'b0;
  logic [1:0]      sub_idx = '0;
  logic [VLEN-1:0] src_a = '0, src_b = '0, acc = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [VLEN-1:0] res;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  qwms_lanes #(.VLEN(VLEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .size_i(size), .sub_idx_i(sub_idx), .src_a_i(src_a), .src_b_i(src_b),
    .acc_i(acc), .out_valid_o(out_valid), .out_ready_i(out_ready), .res_o(res)
  );

  function automatic logic [VLEN-1:0] model(input logic s, input logic [1:0] si,
      input logic [VLEN-1:0] a, input logic [VLEN-1:0] b, input logic [VLEN-1:0] c);
    logic [VLEN-1:0] r;
    int ew, nw;
    longint unsigned emask, nmask, na, nb, ca, v;
    r = '0;
    ew = s ? 64 : 32;
    nw = ew / 4;
    emask = s ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF;
    nmask = (64'd1 << nw) - 1;
    for (int e = 0; e < VLEN / ew; e++) begin
      na = 64'(a >> ((4*e + si) * nw)) & nmask;
      nb = 64'(b >> ((4*e + si) * nw)) & nmask;
      ca = 64'(c >> (e * ew)) & emask;
      v  = (ca - na * nb) & emask;
      r  = r | (VLEN'(v) << (e * ew));
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int k = 0; k < VLEN / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  // drive at negedge, accepted at posedge, result sampled at following negedge
  task automatic run_op(input string req, input logic s, input logic [1:0] si,
      input logic [VLEN-1:0] a, input logic [VLEN-1:0] b, input logic [VLEN-1:0] c);
    size = s; sub_idx = si; src_a = a; src_b = b; acc = c; in_valid = 1'b1;
    #1 check({req, " ready"}, VLEN'(in_ready), VLEN'(1'b1));
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid R6 R10"}, VLEN'(out_valid), VLEN'(1'b1));
    check(req, res, model(s, si, a, b, c));
  endtask

  initial begin
    logic [VLEN-1:0] ra, rb, rc, sa, sb, sc;
    logic [1:0] si;
    logic s;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset valid", VLEN'(out_valid), '0);
    check("R10 reset ready", VLEN'(in_ready), VLEN'(1'b1));
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3: 32-bit, known pattern, each sub-index
    for (int q = 0; q < 4; q++) begin
      for (int k = 0; k < VLEN / 8; k++) begin
        ra[k*8 +: 8] = 8'(k + 1);
        rb[k*8 +: 8] = 8'(3 * k + 2);
      end
      run_op("R1 R3", 1'b0, 2'(q), ra, rb, {(VLEN/32){32'h1000_0000}});
    end
    // R2 R3: 64-bit, each sub-index
    for (int q = 0; q < 4; q++)
      run_op("R2 R3", 1'b1, 2'(q), rnd_vec(), rnd_vec(), rnd_vec());

    // R4: wrap with all-ones sources over zero accumulator
    run_op("R4 wrap32", 1'b0, 2'd3, '1, '1, '0);
    check("R4 lane32", VLEN'(res[31:0]), VLEN'(32'hFFFF_01FF));
    run_op("R4 wrap64", 1'b1, 2'd0, '1, '1, '0);
    check("R4 lane64", VLEN'(res[63:0]), VLEN'(64'hFFFF_FFFF_0001_FFFF));
    // R5: every element changes when all products are nonzero
    run_op("R5 all lanes", 1'b0, 2'd1, '1, '1, '0);
    for (int e = 0; e < VLEN / 32; e++)
      check("R5 lane", VLEN'(res[e*32 +: 32]), VLEN'(32'hFFFF_01FF));

    // R9: drain without new input
    @(negedge clk);
    check("R9 drained", VLEN'(out_valid), '0);
    check("R9 ready empty", VLEN'(in_ready), VLEN'(1'b1));

    // R7 R8: stall, offer different row while blocked
    out_ready = 1'b0;
    ra = rnd_vec(); rb = rnd_vec(); rc = rnd_vec();
    run_op("R7 first", 1'b0, 2'd2, ra, rb, rc);
    sa = rnd_vec(); sb = rnd_vec(); sc = rnd_vec();
    size = 1'b1; sub_idx = 2'd1; src_a = sa; src_b = sb; acc = sc; in_valid = 1'b1;
    for (int c = 0; c < 3; c++) begin
      #1 check("R7 blocked", VLEN'(in_ready), '0);
      @(negedge clk);
      check("R8 held", res, model(1'b0, 2'd2, ra, rb, rc));
      check("R7 valid held", VLEN'(out_valid), VLEN'(1'b1));
    end
    out_ready = 1'b1;
    #1 check("R7 release", VLEN'(in_ready), VLEN'(1'b1));
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 second", res, model(1'b1, 2'd1, sa, sb, sc));
    @(negedge clk);

    // R1 R2 R3 R4 R5: random rows, both sizes, all sub-indices
    for (int t = 0; t < 200; t++) begin
      s  = 1'($urandom);
      si = 2'($urandom);
      run_op(s ? "R2 rnd" : "R1 rnd", s, si, rnd_vec(), rnd_vec(), rnd_vec());
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule